// File: doc/BRIEF.md
# Remappable Memory Chip-Select Decoder

This block turns a 20-bit processor address and its access strobes into chip selects for eight main flash sectors, four boot flash sectors, a static RAM and a small control register window. A fetch strobe marks an access to program space; a read or write strobe marks an access to data space. Each flash array can be placed in program space, data space, both, or neither, so the same address can reach different memories depending on the kind of access.

Two registers inside the control window reshape the map at run time. A placement register says in which space each flash array is decoded. A page register carries a swap bit. The swap bit trades the lowest 16 KB of the boot region with the top main flash sector. Software boots from boot flash, moves main flash into program space, sets the swap bit so main flash answers at address zero, and may then move boot flash into data space to rewrite it. Every reset returns the map to its boot-time form.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the placement register holds 0x12 and the swap bit is 0, so a fetch at 0x00000 selects boot sector 0 and a read at 0x10000 selects main sector 0.
- R2: With swap clear and main flash enabled in the access's space, main sector k (0..7) is selected for addresses 0x10000 + k*0x4000 through 0x13FFF + k*0x4000.
- R3: With swap clear and boot flash enabled in the access's space, boot sector j (0..3) is selected for addresses j*0x2000 through j*0x2000 + 0x1FFF.
- R4: The SRAM answers data accesses at 0x01000–0x017FF and the control window answers data accesses at 0x01800–0x018FF; neither is ever selected by a fetch.
- R5: Placement bit 1 enables boot flash in program space, bit 2 main flash in program space, bit 3 boot flash in data space, bit 4 main flash in data space; a flash array whose bit for the current space is clear is never selected.
- R6: A data write (wr high, fetch low) to 0x018C0 loads the placement register and one to 0x018E0 loads the page register, whose bit 7 is the swap bit; the new value applies from the next clock cycle, and writes to other offsets of the window change neither.
- R7: With swap set, main sector 7 answers at 0x00000–0x03FFF, boot sectors 0 and 1 answer at 0x2C000–0x2DFFF and 0x2E000–0x2FFFF, and boot sectors 2 and 3 keep their addresses.
- R8: In data space the control window wins over the SRAM, and the SRAM wins over any flash sector decoded at the same address.
- R9: At most one select is active at a time; when a strobe is active and no select is, unmapped is high; with no strobe active, no select and no unmapped are driven.
- R10: When fetch is high the access is a program-space access even if rd or wr is also high, and such an access never writes a register.
- R11: Asserting reset at any time restores placement 0x12 and swap 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 20 | Access address |
| fetch | input | 1 | Program-space access strobe |
| rd | input | 1 | Data-space read strobe |
| wr | input | 1 | Data-space write strobe |
| wdata | input | 8 | Write data for the control window registers |
| main_cs | output | 8 | Main flash sector selects, one bit per sector |
| boot_cs | output | 4 | Boot flash sector selects, one bit per sector |
| sram_cs | output | 1 | SRAM select |
| ctrl_cs | output | 1 | Control window select |
| unmapped | output | 1 | Active access hit no enabled region |

## Verification
The bench builds the decoder with its default parameters: a 20-bit address, eight 16 KB main sectors and four 8 KB boot sectors, so one swap moves exactly two boot sectors and leaves two in place. These values put the SRAM and control window on top of boot sector 0, which lets the data-space priority be reached once boot flash is moved to data space. The bench walks the boot, move-main, swap and move-boot steps and probes sector edges, overlaps and holes at every step.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_PROG = 2'd1,
    SPACE_DATA = 2'd2
  } space_e;

  // Bit positions inside the placement register
  localparam int unsigned PL_BOOT_PROG = 1;
  localparam int unsigned PL_MAIN_PROG = 2;
  localparam int unsigned PL_BOOT_DATA = 3;
  localparam int unsigned PL_MAIN_DATA = 4;

  function automatic logic win_hit(input logic [31:0] a,
                                   input logic [31:0] base,
                                   input logic [31:0] size);
    return (a >= base) && (a < base + size);
  endfunction

endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned PLACE_OFS = 32'hC0,
  parameter int unsigned PAGE_OFS  = 32'hE0,
  parameter int unsigned PLACE_RST = 32'h12,
  parameter int unsigned SWAP_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] place,
  output logic              swap
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_int_n = rst_pipe[1];

  logic [DATA_W-1:0] place_q, place_d;
  logic [DATA_W-1:0] page_q, page_d;
  logic              place_en, page_en;

  always_comb begin
    place_en = wr_en && (ofs == OFS_W'(PLACE_OFS));
    page_en  = wr_en && (ofs == OFS_W'(PAGE_OFS));
    place_d  = wdata;
    page_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      place_q <= DATA_W'(PLACE_RST);
      page_q  <= '0;
    end else begin
      if (place_en) place_q <= place_d;
      if (page_en)  page_q  <= page_d;
    end
  end

  assign place = place_q;
  assign swap  = page_q[SWAP_BIT];

endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MAIN_N    = 8,
  parameter int unsigned BOOT_N    = 4,
  parameter int unsigned MAIN_BASE = 32'h10000,
  parameter int unsigned MAIN_SZ   = 32'h4000,
  parameter int unsigned BOOT_BASE = 32'h00000,
  parameter int unsigned BOOT_SZ   = 32'h2000,
  parameter int unsigned SRAM_BASE = 32'h01000,
  parameter int unsigned SRAM_SZ   = 32'h800,
  parameter int unsigned CTRL_BASE = 32'h01800,
  parameter int unsigned CTRL_SZ   = 32'h100
) (
  input  logic [ADDR_W-1:0] addr,
  input  space_e            space,
  input  logic [DATA_W-1:0] place,
  input  logic              swap,
  output logic [MAIN_N-1:0] main_hit,
  output logic [BOOT_N-1:0] boot_hit,
  output logic              sram_hit,
  output logic              ctrl_hit
);

  localparam int unsigned TOP_IDX       = MAIN_N - 1;
  localparam int unsigned MAIN_TOP_BASE = MAIN_BASE + TOP_IDX * MAIN_SZ;
  localparam int unsigned SWAP_BOOT_N   = MAIN_SZ / BOOT_SZ;

  logic [31:0] a32;
  logic        main_en, boot_en, data_acc;

  always_comb begin
    a32      = 32'(addr);
    data_acc = (space == SPACE_DATA);
    main_en  = ((space == SPACE_PROG) && place[PL_MAIN_PROG]) ||
               (data_acc && place[PL_MAIN_DATA]);
    boot_en  = ((space == SPACE_PROG) && place[PL_BOOT_PROG]) ||
               (data_acc && place[PL_BOOT_DATA]);
    sram_hit = data_acc && win_hit(a32, SRAM_BASE, SRAM_SZ);
    ctrl_hit = data_acc && win_hit(a32, CTRL_BASE, CTRL_SZ);
  end

  for (genvar k = 0; k < MAIN_N; k++) begin : g_main
    localparam logic [31:0] NORM = MAIN_BASE + k * MAIN_SZ;
    logic [31:0] base;
    if (k == TOP_IDX) begin : g_top
      assign base = swap ? 32'(BOOT_BASE) : NORM;
    end else begin : g_fix
      assign base = NORM;
    end
    assign main_hit[k] = main_en && win_hit(a32, base, MAIN_SZ);
  end

  for (genvar j = 0; j < BOOT_N; j++) begin : g_boot
    localparam logic [31:0] NORM = BOOT_BASE + j * BOOT_SZ;
    logic [31:0] base;
    if (j < SWAP_BOOT_N) begin : g_mov
      localparam logic [31:0] ALT = MAIN_TOP_BASE + j * BOOT_SZ;
      assign base = swap ? ALT : NORM;
    end else begin : g_fix
      assign base = NORM;
    end
    assign boot_hit[j] = boot_en && win_hit(a32, base, BOOT_SZ);
  end

endmodule

// File: rtl/memmap_sel_arb.sv
module memmap_sel_arb
  import memmap_pkg::*;
#(
  parameter int unsigned MAIN_N = 8,
  parameter int unsigned BOOT_N = 4
) (
  input  space_e            space,
  input  logic [MAIN_N-1:0] main_hit,
  input  logic [BOOT_N-1:0] boot_hit,
  input  logic              sram_hit,
  input  logic              ctrl_hit,
  output logic [MAIN_N-1:0] main_cs,
  output logic [BOOT_N-1:0] boot_cs,
  output logic              sram_cs,
  output logic              ctrl_cs,
  output logic              unmapped
);

  logic over_flash, any_sel;

  // priority: control window, SRAM, boot flash, main flash
  always_comb begin
    ctrl_cs    = ctrl_hit;
    sram_cs    = sram_hit && !ctrl_hit;
    over_flash = ctrl_hit || sram_hit;
    boot_cs    = over_flash ? '0 : boot_hit;
    main_cs    = (over_flash || (|boot_hit)) ? '0 : main_hit;
    any_sel    = ctrl_cs || sram_cs || (|boot_cs) || (|main_cs);
    unmapped   = (space != SPACE_NONE) && !any_sel;
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MAIN_N    = 8,
  parameter int unsigned BOOT_N    = 4,
  parameter int unsigned MAIN_BASE = 32'h10000,
  parameter int unsigned MAIN_SZ   = 32'h4000,
  parameter int unsigned BOOT_BASE = 32'h00000,
  parameter int unsigned BOOT_SZ   = 32'h2000,
  parameter int unsigned SRAM_BASE = 32'h01000,
  parameter int unsigned SRAM_SZ   = 32'h800,
  parameter int unsigned CTRL_BASE = 32'h01800,
  parameter int unsigned CTRL_SZ   = 32'h100,
  parameter int unsigned PLACE_OFS = 32'hC0,
  parameter int unsigned PAGE_OFS  = 32'hE0,
  parameter int unsigned PLACE_RST = 32'h12,
  parameter int unsigned SWAP_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [MAIN_N-1:0] main_cs,
  output logic [BOOT_N-1:0] boot_cs,
  output logic              sram_cs,
  output logic              ctrl_cs,
  output logic              unmapped
);

  localparam int unsigned OFS_W = $clog2(CTRL_SZ);

  space_e            space;
  logic [DATA_W-1:0] place;
  logic              swap;
  logic              cfg_wr_en;
  logic [MAIN_N-1:0] main_hit;
  logic [BOOT_N-1:0] boot_hit;
  logic              sram_hit, ctrl_hit;

  always_comb begin
    if (fetch)          space = SPACE_PROG;
    else if (rd || wr)  space = SPACE_DATA;
    else                space = SPACE_NONE;
    cfg_wr_en = wr && (space == SPACE_DATA) && ctrl_cs;
  end

  memmap_cfg_regs #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .PLACE_OFS(PLACE_OFS),
    .PAGE_OFS(PAGE_OFS), .PLACE_RST(PLACE_RST), .SWAP_BIT(SWAP_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
    .ofs(addr[OFS_W-1:0]), .wdata(wdata),
    .place(place), .swap(swap)
  );

  memmap_region_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_N(MAIN_N), .BOOT_N(BOOT_N),
    .MAIN_BASE(MAIN_BASE), .MAIN_SZ(MAIN_SZ),
    .BOOT_BASE(BOOT_BASE), .BOOT_SZ(BOOT_SZ),
    .SRAM_BASE(SRAM_BASE), .SRAM_SZ(SRAM_SZ),
    .CTRL_BASE(CTRL_BASE), .CTRL_SZ(CTRL_SZ)
  ) u_dec (
    .addr(addr), .space(space), .place(place), .swap(swap),
    .main_hit(main_hit), .boot_hit(boot_hit),
    .sram_hit(sram_hit), .ctrl_hit(ctrl_hit)
  );

  memmap_sel_arb #(.MAIN_N(MAIN_N), .BOOT_N(BOOT_N)) u_arb (
    .space(space), .main_hit(main_hit), .boot_hit(boot_hit),
    .sram_hit(sram_hit), .ctrl_hit(ctrl_hit),
    .main_cs(main_cs), .boot_cs(boot_cs),
    .sram_cs(sram_cs), .ctrl_cs(ctrl_cs), .unmapped(unmapped)
  );

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
  parameter int unsigned MAIN_N    = 8,
  parameter int unsigned BOOT_N    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PLACE_RST = 32'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch,
  input logic              rd,
  input logic              wr,
  input logic [MAIN_N-1:0] main_cs,
  input logic [BOOT_N-1:0] boot_cs,
  input logic              sram_cs,
  input logic              ctrl_cs,
  input logic              unmapped,
  input logic [DATA_W-1:0] place,
  input logic              swap,
  input logic              wr_en
);

  logic [MAIN_N+BOOT_N+1:0] sels;
  assign sels = {main_cs, boot_cs, sram_cs, ctrl_cs};

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  // R9
  unmapped_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (sels == '0) && (fetch || rd || wr));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch || rd || wr) |-> (sels == '0) && !unmapped);

  // R4
  fetch_no_data_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> !sram_cs && !ctrl_cs);

  // R5
  prog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !place[1] && !place[2]) |-> (main_cs == '0) && (boot_cs == '0));

  // R6
  place_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(place) && $stable(swap));

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (place == DATA_W'(PLACE_RST)) && !swap);

endmodule

bind memmap_decoder memmap_decoder_chk #(
  .MAIN_N(MAIN_N), .BOOT_N(BOOT_N), .DATA_W(DATA_W), .PLACE_RST(PLACE_RST)
) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch(fetch), .rd(rd), .wr(wr),
  .main_cs(main_cs), .boot_cs(boot_cs), .sram_cs(sram_cs),
  .ctrl_cs(ctrl_cs), .unmapped(unmapped),
  .place(place), .swap(swap), .wr_en(cfg_wr_en)
);

// File: tb/test_memmap_decoder.sv
`timescale 1ns/1ps
module test_memmap_decoder;

  localparam int M_IDLE  = 0;
  localparam int M_FETCH = 1;
  localparam int M_READ  = 2;
  localparam int M_BOTH  = 3;
  localparam real HALF   = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] addr;
  logic        fetch, rd, wr;
  logic [7:0]  wdata;
  logic [7:0]  main_cs;
  logic [3:0]  boot_cs;
  logic        sram_cs, ctrl_cs, unmapped;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(HALF) clk = ~clk;

  memmap_decoder i_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fetch(fetch), .rd(rd), .wr(wr),
    .wdata(wdata), .main_cs(main_cs), .boot_cs(boot_cs),
    .sram_cs(sram_cs), .ctrl_cs(ctrl_cs), .unmapped(unmapped)
  );

  // observed vector: {unmapped, ctrl, sram, boot[3:0], main[7:0]}
  function automatic logic [14:0] e_main(int k); return 15'(1) << k;       endfunction
  function automatic logic [14:0] e_boot(int j); return 15'(1) << (8 + j); endfunction
  localparam logic [14:0] E_SRAM = 15'(1) << 12;
  localparam logic [14:0] E_CTRL = 15'(1) << 13;
  localparam logic [14:0] E_UNM  = 15'(1) << 14;
  localparam logic [14:0] E_NONE = 15'd0;

  task automatic probe(input string tag, input int mode,
                       input logic [19:0] a, input logic [14:0] exp);
    logic [14:0] got;
    @(negedge clk);
    addr  = a;
    fetch = (mode == M_FETCH) || (mode == M_BOTH);
    rd    = (mode == M_READ)  || (mode == M_BOTH);
    wr    = 1'b0;
    #1;
    got = {unmapped, ctrl_cs, sram_cs, boot_cs, main_cs};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%05h mode=%0d actual=%015b expected=%015b",
               tag, a, mode, got, exp);
    end
    fetch = 1'b0;
    rd    = 1'b0;
  endtask

  task automatic wr_reg(input logic [19:0] a, input logic [7:0] d,
                        input logic with_fetch);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    rd    = 1'b0;
    fetch = with_fetch;
    @(negedge clk);
    wr    = 1'b0;
    fetch = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_boot_map();
    probe("R1 fetch boot0",  M_FETCH, 20'h00000, e_boot(0));
    probe("R1 read main0",   M_READ,  20'h10000, e_main(0));
    probe("R3 fetch boot3",  M_FETCH, 20'h07FFF, e_boot(3));
    probe("R3 fetch boot1",  M_FETCH, 20'h02000, e_boot(1));
    probe("R2 read main0 end", M_READ, 20'h13FFF, e_main(0));
    probe("R2 read main1",   M_READ,  20'h14000, e_main(1));
    probe("R2 read main7",   M_READ,  20'h2C000, e_main(7));
    probe("R2 read main7 end", M_READ, 20'h2FFFF, e_main(7));
    probe("R5 fetch main off", M_FETCH, 20'h10000, E_UNM);
    probe("R5 read boot off", M_READ, 20'h06000, E_UNM);
    probe("R9 idle",         M_IDLE,  20'h10000, E_NONE);
    probe("R9 hole",         M_READ,  20'h30000, E_UNM);
  endtask

  task automatic t_windows();
    probe("R4 sram lo",      M_READ,  20'h01000, E_SRAM);
    probe("R4 sram hi",      M_READ,  20'h017FF, E_SRAM);
    probe("R4 ctrl lo",      M_READ,  20'h01800, E_CTRL);
    probe("R4 ctrl hi",      M_READ,  20'h018FF, E_CTRL);
    probe("R4 past ctrl",    M_READ,  20'h01900, E_UNM);
    probe("R4 fetch in ctrl", M_FETCH, 20'h01800, e_boot(0));
    probe("R4 fetch in sram", M_FETCH, 20'h01000, e_boot(0));
  endtask

  task automatic t_stray_writes();
    wr_reg(20'h018C1, 8'h00, 1'b0);
    probe("R6 stray place ofs", M_FETCH, 20'h00000, e_boot(0));
    wr_reg(20'h018E1, 8'h80, 1'b0);
    probe("R6 stray page ofs",  M_FETCH, 20'h00000, e_boot(0));
    wr_reg(20'h018C0, 8'h0C, 1'b1);
    probe("R10 fetch blocks write", M_READ, 20'h10000, e_main(0));
    probe("R10 fetch wins",  M_BOTH,  20'h01000, e_boot(0));
  endtask

  task automatic t_main_to_prog();
    wr_reg(20'h018C0, 8'h06, 1'b0);
    probe("R6 place 06 main prog", M_FETCH, 20'h10000, e_main(0));
    probe("R5 place 06 boot prog", M_FETCH, 20'h00000, e_boot(0));
    probe("R5 place 06 main not data", M_READ, 20'h10000, E_UNM);
  endtask

  task automatic t_swap();
    wr_reg(20'h018E0, 8'h80, 1'b0);
    probe("R7 main7 at 0",   M_FETCH, 20'h00000, e_main(7));
    probe("R7 main7 end",    M_FETCH, 20'h03FFF, e_main(7));
    probe("R7 boot0 moved",  M_FETCH, 20'h2C000, e_boot(0));
    probe("R7 boot1 moved",  M_FETCH, 20'h2FFFF, e_boot(1));
    probe("R7 boot2 stays",  M_FETCH, 20'h04000, e_boot(2));
    probe("R7 boot3 stays",  M_FETCH, 20'h06000, e_boot(3));
    probe("R7 main6 stays",  M_FETCH, 20'h28000, e_main(6));
  endtask

  task automatic t_boot_to_data();
    wr_reg(20'h018C0, 8'h0C, 1'b0);
    probe("R5 place 0C main prog", M_FETCH, 20'h10000, e_main(0));
    probe("R7 boot0 data swapped", M_READ, 20'h2C000, e_boot(0));
    probe("R5 place 0C boot not prog", M_FETCH, 20'h2C000, E_UNM);
    probe("R7 main7 prog at 0", M_FETCH, 20'h00000, e_main(7));
    probe("R5 place 0C boot2 data", M_READ, 20'h04000, e_boot(2));
    wr_reg(20'h018E0, 8'h00, 1'b0);
    probe("R8 sram over boot0", M_READ, 20'h01000, E_SRAM);
    probe("R8 ctrl over boot0", M_READ, 20'h01800, E_CTRL);
    probe("R8 boot0 below sram", M_READ, 20'h00FFF, e_boot(0));
    probe("R6 swap cleared", M_FETCH, 20'h2C000, e_main(7));
  endtask

  task automatic t_reset_again();
    do_reset();
    probe("R11 fetch boot0", M_FETCH, 20'h00000, e_boot(0));
    probe("R11 read main0",  M_READ,  20'h10000, e_main(0));
    probe("R11 main7 home",  M_READ,  20'h2C000, e_main(7));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr  = '0;
    fetch = 1'b0;
    rd    = 1'b0;
    wr    = 1'b0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_boot_map();
    t_windows();
    t_stray_writes();
    t_main_to_prog();
    t_swap();
    t_boot_to_data();
    t_reset_again();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule